// File: doc/BRIEF.md
# Delta-Modulation Sample Playback Channel

This block plays back a 1-bit delta-coded sample stream. Software programs a rate and mode register, a start-address field and a length field, then sets the enable bit. The channel reads sample bytes one at a time through a simple request/valid memory port. It shifts each byte out least-significant bit first, one bit per rate tick. Each bit moves a 6-bit level counter one step up or down, and the counter stops at its limits.

The output is the 7-bit value formed by the level counter and a separate low bit. A direct-load write can set this value at any time. When the byte count runs out, the channel either restarts from the programmed start point or stops. When it stops, it can raise an interrupt flag, depending on the mode.

Top module: `delta_sample_channel`

## Requirements
- R1: After reset, `level_out` is 0, `active` is 0, `irq` is 0 and `mem_req` is 0.
- R2: Writes select a register through `cfg_sel`: 0 = rate/mode, 1 = direct level, 2 = start address, 3 = length. In the rate/mode register, bits 3:0 pick the tick period in clocks: 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54 for indices 0..15. A write to this register restarts the period count, so the first tick comes exactly one period after the write.
- R3: On a tick while the shifter holds bits, a bit of 1 raises the 6-bit level by one unless it is 63, and a bit of 0 lowers it by one unless it is 0. Bits are taken LSB first. A tick with an empty shifter changes nothing.
- R4: A direct-level write loads the level from data bits 6:1 and the output low bit from data bit 0, so `level_out` equals data[6:0] on the next cycle. If a tick falls in the same cycle, the load wins, and that tick's bit is still used up.
- R5: A start sets the current address to 0xC000 OR (start field << 6) and the byte count to (length field × 16) + 1. `mem_req` is raised only while the channel is active and the shifter is empty. A byte is loaded on the cycle when `mem_valid` and `mem_req` are both high.
- R6: After each fetched byte, the address increases by one and wraps from 0xFFFF to 0x8000 (bit 15 always set), and the byte count decreases by one.
- R7: When the last byte is fetched, the channel reloads the start address and count if mode bit 6 is set; otherwise it becomes inactive. In that case `irq` is set only if mode bits 7:6 equal 2.
- R8: A write with `en_bit`=1 starts playback and clears `irq` only when the channel is inactive; while it is active, this write has no effect. A write with `en_bit`=0 makes it inactive on the next cycle, and `mem_req` falls.
- R9: Writes to the start-address and length registers during playback do not change the address or count of the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 rate/mode, 1 level, 2 start, 3 length) |
| cfg_data | input | 8 | Register write data |
| en_wr | input | 1 | Enable-bit write strobe |
| en_bit | input | 1 | Enable value written |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_data | input | 8 | Returned byte |
| mem_valid | input | 1 | Returned byte is valid |
| level_out | output | 7 | Output level {counter, low bit} |
| active | output | 1 | Playback in progress |
| irq | output | 1 | End-of-sample interrupt flag |

## Verification
A direct-level write and a rate-tick step can land on the same clock edge, and both want to change the level register. The bench plays a looping all-ones byte and detects one tick by watching the level change. It then times a direct load to reach the register exactly one period later. It checks that the loaded value appears unchanged on that edge and that the following tick steps up from the loaded value.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_LEVEL = 2'd1,
      SEL_START = 2'd2,
      SEL_LEN   = 2'd3
   } cfg_sel_e;

   localparam int RATE_IDX_W = 4;
   localparam int PERIOD_W   = 9;

   function automatic logic [PERIOD_W-1:0] period_main(input logic [RATE_IDX_W-1:0] i);
      case (i)
         4'd0:    return 9'd428;
         4'd1:    return 9'd380;
         4'd2:    return 9'd340;
         4'd3:    return 9'd320;
         4'd4:    return 9'd286;
         4'd5:    return 9'd254;
         4'd6:    return 9'd226;
         4'd7:    return 9'd214;
         4'd8:    return 9'd190;
         4'd9:    return 9'd160;
         4'd10:   return 9'd142;
         4'd11:   return 9'd128;
         4'd12:   return 9'd106;
         4'd13:   return 9'd84;
         4'd14:   return 9'd72;
         default: return 9'd54;
      endcase
   endfunction

   function automatic logic [PERIOD_W-1:0] period_alt(input logic [RATE_IDX_W-1:0] i);
      case (i)
         4'd0:    return 9'd398;
         4'd1:    return 9'd354;
         4'd2:    return 9'd316;
         4'd3:    return 9'd298;
         4'd4:    return 9'd276;
         4'd5:    return 9'd236;
         4'd6:    return 9'd210;
         4'd7:    return 9'd198;
         4'd8:    return 9'd176;
         4'd9:    return 9'd148;
         4'd10:   return 9'd132;
         4'd11:   return 9'd118;
         4'd12:   return 9'd98;
         4'd13:   return 9'd78;
         4'd14:   return 9'd66;
         default: return 9'd50;
      endcase
   endfunction

endpackage

// File: rtl/dsc_rate_timer.sv
module dsc_rate_timer
   import dsc_pkg::*;
#(
   parameter int PER_W     = 9,
   parameter bit ALT_RATES = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  restart,
   input  logic [RATE_IDX_W-1:0] rate_idx,
   output logic                  tick
);

   logic [PER_W-1:0] period;
   logic [PER_W-1:0] cnt;

   generate
      if (PER_W < PERIOD_W) begin : g_bad_width
         $error("dsc_rate_timer: PER_W too small for period table");
      end
      if (ALT_RATES) begin : g_alt
         assign period = PER_W'(period_alt(rate_idx));
      end else begin : g_main
         assign period = PER_W'(period_main(rate_idx));
      end
   endgenerate

   assign tick = (cnt == period - PER_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + PER_W'(1);
   end

   // R2: shortest period is far above one clock, so ticks never come back to back
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/dsc_shifter.sv
module dsc_shifter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          tick,
   output logic          empty,
   output logic          step,
   output logic          bit_out
);

   localparam int CW = $clog2(DW + 1);

   logic [DW-1:0] sh;
   logic [CW-1:0] left;

   assign empty   = (left == '0);
   assign step    = tick && !empty;
   assign bit_out = sh[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         left <= '0;
      end else if (load) begin
         sh   <= load_data;
         left <= CW'(DW);
      end else if (step) begin
         sh   <= sh >> 1;
         left <= left - CW'(1);
      end
   end

   // R5: a new byte only arrives into an empty shifter
   assert_load_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> empty);

   // R3: bit count never exceeds one byte
   assert_left_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      left <= CW'(DW));

endmodule

// File: rtl/dsc_level.sv
module dsc_level #(
   parameter int LVL_W = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [LVL_W:0] load_val,
   input  logic           step,
   input  logic           up,
   output logic [LVL_W:0] level_out
);

   localparam logic [LVL_W-1:0] LMAX = {LVL_W{1'b1}};

   logic [LVL_W-1:0] lvl;
   logic             lsb;

   assign level_out = {lvl, lsb};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl <= '0;
         lsb <= 1'b0;
      end else if (load) begin
         lvl <= load_val[LVL_W:1];
         lsb <= load_val[0];
      end else if (step) begin
         if (up && lvl != LMAX)       lvl <= lvl + LVL_W'(1);
         else if (!up && lvl != '0)   lvl <= lvl - LVL_W'(1);
      end
   end

   // R3: without a load the level moves by at most one per cycle
   assert_step_le1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> (lvl == $past(lvl) || lvl == LVL_W'($past(lvl) + LVL_W'(1))
                        || lvl == LVL_W'($past(lvl) - LVL_W'(1))));

   // R3: saturation, never wraps past the top or bottom
   assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lvl) == LMAX && !$past(load)) |-> lvl != '0);
   assert_no_wrap_bot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lvl) == '0 && !$past(load)) |-> lvl != LMAX);

endmodule

// File: rtl/dsc_fetch_ctrl.sv
module dsc_fetch_ctrl #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 8,
   parameter int OFS_SH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  start_field,
   input  logic [LEN_W-1:0]  len_field,
   input  logic              loop_en,
   input  logic              irq_mode,
   input  logic              start_wr,
   input  logic              stop_wr,
   input  logic              shifter_empty,
   input  logic              mem_valid,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              fetch_done,
   output logic              active,
   output logic              irq
);

   localparam int CNT_W = LEN_W + 5;
   localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(3) << (ADDR_W - 2);
   localparam logic [ADDR_W-1:0] TOPBIT = ADDR_W'(1) << (ADDR_W - 1);

   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  remain;
   logic [ADDR_W-1:0] start_val;
   logic [CNT_W-1:0]  cnt_init;
   logic [ADDR_W-1:0] next_addr;

   assign start_val  = BASE | (ADDR_W'(start_field) << OFS_SH);
   assign cnt_init   = (CNT_W'(len_field) << 4) + CNT_W'(1);
   assign next_addr  = (cur_addr + ADDR_W'(1)) | TOPBIT;
   assign mem_req    = active && shifter_empty;
   assign mem_addr   = cur_addr;
   assign fetch_done = mem_req && mem_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         remain   <= '0;
         active   <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (fetch_done) begin
            if (remain == CNT_W'(1)) begin
               if (loop_en) begin
                  cur_addr <= start_val;
                  remain   <= cnt_init;
               end else begin
                  active <= 1'b0;
                  irq    <= irq_mode;
               end
            end else begin
               cur_addr <= next_addr;
               remain   <= remain - CNT_W'(1);
            end
         end
         if (start_wr && !active) begin
            active   <= 1'b1;
            cur_addr <= start_val;
            remain   <= cnt_init;
            irq      <= 1'b0;
         end
         if (stop_wr) active <= 1'b0;
      end
   end

   // R6: every requested address lies in the upper half
   assert_req_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[ADDR_W-1]);

   // R7: the interrupt only rises as playback ends
   assert_irq_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $fell(active));

   // R5: an active transfer always has bytes left
   assert_remain_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> remain != '0);

endmodule

// File: rtl/delta_sample_channel.sv
module delta_sample_channel
   import dsc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int LVL_W     = 6,
   parameter int PER_W     = 9,
   parameter bit ALT_RATES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic              en_wr,
   input  logic              en_bit,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   input  logic              mem_valid,
   output logic [LVL_W:0]    level_out,
   output logic              active,
   output logic              irq
);

   localparam int OFS_SH = 6;

   generate
      if (ADDR_W < DATA_W + OFS_SH + 2) begin : g_bad_addr
         $error("delta_sample_channel: ADDR_W too small for start field");
      end
      if (LVL_W + 1 > DATA_W) begin : g_bad_lvl
         $error("delta_sample_channel: level wider than write data");
      end
   endgenerate

   logic [1:0]            mode;
   logic [RATE_IDX_W-1:0] rate_idx;
   logic [DATA_W-1:0]     start_field;
   logic [DATA_W-1:0]     len_field;

   logic wr_ctrl, wr_level;
   logic tick, empty, step, bit_now, fetch_done;

   assign wr_ctrl  = cfg_wr && (cfg_sel == SEL_CTRL);
   assign wr_level = cfg_wr && (cfg_sel == SEL_LEVEL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode        <= '0;
         rate_idx    <= '0;
         start_field <= '0;
         len_field   <= '0;
      end else if (cfg_wr) begin
         case (cfg_sel)
            SEL_CTRL: begin
               mode     <= cfg_data[7:6];
               rate_idx <= cfg_data[RATE_IDX_W-1:0];
            end
            SEL_START: start_field <= cfg_data;
            SEL_LEN:   len_field   <= cfg_data;
            default: ;
         endcase
      end
   end

   dsc_rate_timer #(.PER_W(PER_W), .ALT_RATES(ALT_RATES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (wr_ctrl),
      .rate_idx (rate_idx),
      .tick     (tick)
   );

   dsc_fetch_ctrl #(.ADDR_W(ADDR_W), .LEN_W(DATA_W), .OFS_SH(OFS_SH)) u_fetch (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_field   (start_field),
      .len_field     (len_field),
      .loop_en       (mode[0]),
      .irq_mode      (mode == 2'd2),
      .start_wr      (en_wr && en_bit),
      .stop_wr       (en_wr && !en_bit),
      .shifter_empty (empty),
      .mem_valid     (mem_valid),
      .mem_req       (mem_req),
      .mem_addr      (mem_addr),
      .fetch_done    (fetch_done),
      .active        (active),
      .irq           (irq)
   );

   dsc_shifter #(.DW(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (fetch_done),
      .load_data (mem_data),
      .tick      (tick),
      .empty     (empty),
      .step      (step),
      .bit_out   (bit_now)
   );

   dsc_level #(.LVL_W(LVL_W)) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_level),
      .load_val  (cfg_data[LVL_W:0]),
      .step      (step),
      .up        (bit_now),
      .level_out (level_out)
   );

   // R5: requests never appear while stopped
   assert_req_when_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> active);

endmodule

// File: tb/delta_sample_channel_tb.sv
`timescale 1ns/1ps
module delta_sample_channel_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [1:0]  cfg_sel;
   logic [7:0]  cfg_data;
   logic        en_wr, en_bit;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic [7:0]  mem_data;
   logic        mem_valid;
   logic [6:0]  level_out;
   logic        active, irq;

   always #10 clk = ~clk;

   delta_sample_channel u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .en_wr(en_wr), .en_bit(en_bit), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_valid(mem_valid), .level_out(level_out),
      .active(active), .irq(irq)
   );

   int errs = 0;
   int checks = 0;
   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [7:0]  mem_byte = 8'h00;
   logic [15:0] addr_log [0:127];
   int          nfetch = 0;

   // memory responder: answers a request one half cycle later, at negedges
   initial begin
      mem_valid = 1'b0;
      mem_data  = 8'h00;
      forever begin
         @(negedge clk);
         if (mem_valid) mem_valid = 1'b0;
         else if (mem_req) begin
            mem_valid = 1'b1;
            mem_data  = mem_byte;
            if (nfetch < 128) addr_log[nfetch] = mem_addr;
            nfetch++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic enable(input logic b);
      @(negedge clk);
      en_wr = 1'b1; en_bit = b;
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_inactive(input int maxc);
      for (int i = 0; i < maxc && active; i++) @(negedge clk);
   endtask

   function automatic int period_of(input int idx);
      int p [16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                     190, 160, 142, 128, 106, 84, 72, 54};
      return p[idx];
   endfunction

   function automatic logic [6:0] model(input logic [6:0] l, input logic [7:0] b);
      int v = int'(l[6:1]);
      for (int k = 0; k < 8; k++) begin
         if (b[k] && v < 63) v++;
         else if (!b[k] && v > 0) v--;
      end
      return {6'(v), l[0]};
   endfunction

   // {mode[1:0], direct level[6:0], sample byte[7:0]}
   localparam logic [16:0] VEC [0:5] = '{
      {2'd0, 7'h40, 8'hFF},
      {2'd2, 7'h7E, 8'hFF},
      {2'd0, 7'h01, 8'h00},
      {2'd2, 7'h21, 8'hA5},
      {2'd0, 7'h04, 8'h00},
      {2'd2, 7'h7C, 8'h0F}
   };

   task automatic measure(input int idx);
      logic [6:0] prev;
      longint t1, t2;
      enable(1'b0);
      cfg(2'd0, {2'b01, 2'b00, 4'(idx)});
      cfg(2'd2, 8'h00);
      cfg(2'd3, 8'h00);
      cfg(2'd1, 7'h20);
      mem_byte = 8'hFF;
      enable(1'b1);
      prev = level_out;
      t1 = 0; t2 = 0;
      for (int i = 0; i < 1000 && level_out == prev; i++) @(negedge clk);
      t1 = cyc; prev = level_out;
      for (int i = 0; i < 1000 && level_out == prev; i++) @(negedge clk);
      t2 = cyc;
      chk(t2 - t1 == longint'(period_of(idx)), "R2 tick period", int'(t2 - t1), period_of(idx));
      enable(1'b0);
      wait_cyc(9 * period_of(idx));
   endtask

   initial begin
      logic [6:0] prev;
      bit all_same;
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_data = 8'h00;
      en_wr = 1'b0; en_bit = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(level_out == 7'h00, "R1 level", level_out, 0);
      chk(active == 1'b0, "R1 active", active, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);

      // R4 direct load
      cfg(2'd1, 8'hD5);
      chk(level_out == 7'h55, "R4 direct load", level_out, 7'h55);

      // table of single-byte samples
      for (int r = 0; r < 6; r++) begin
         logic [1:0] m;
         logic [6:0] l;
         logic [7:0] b;
         {m, l, b} = VEC[r];
         enable(1'b0);
         cfg(2'd0, {m, 2'b00, 4'hF});
         cfg(2'd2, 8'h00);
         cfg(2'd3, 8'h00);
         cfg(2'd1, {1'b0, l});
         mem_byte = b;
         enable(1'b1);
         chk(active == 1'b1, "R8 start sets active", active, 1);
         chk(irq == 1'b0, "R8 start clears irq", irq, 0);
         wait_cyc(10 * 54);
         chk(level_out == model(l, b), "R3 level after byte", level_out, model(l, b));
         chk(irq == (m == 2'd2), "R7 irq by mode", irq, int'(m == 2'd2));
         chk(active == 1'b0, "R7 ends after single byte", active, 0);
      end

      // R2 periods
      measure(0);
      measure(9);
      measure(15);

      // R4 collision of direct load and tick
      cfg(2'd0, {2'b01, 2'b00, 4'hF});
      cfg(2'd1, 7'h20);
      mem_byte = 8'hFF;
      enable(1'b1);
      prev = level_out;
      for (int i = 0; i < 500 && level_out == prev; i++) @(negedge clk);
      wait_cyc(52);
      cfg(2'd1, 8'h08);
      chk(level_out == 7'h08, "R4 load wins over tick", level_out, 7'h08);
      wait_cyc(53);
      chk(level_out == 7'h08, "R4 holds until next tick", level_out, 7'h08);
      wait_cyc(1);
      chk(level_out == 7'h0A, "R4 next tick steps from loaded", level_out, 7'h0A);
      enable(1'b0);
      wait_cyc(10 * 54);

      // R5 start address / count, R9 and R8 ignored writes mid-transfer
      cfg(2'd0, {2'b00, 2'b00, 4'hF});
      cfg(2'd2, 8'h12);
      cfg(2'd3, 8'h01);
      mem_byte = 8'h00;
      nfetch = 0;
      enable(1'b1);
      wait_cyc(5 * 432);
      cfg(2'd2, 8'h00);
      cfg(2'd3, 8'h00);
      enable(1'b1);
      wait_inactive(20 * 432);
      chk(nfetch == 17, "R5 R9 byte count", nfetch, 17);
      chk(addr_log[0] == 16'hC480, "R5 start address", addr_log[0], 16'hC480);
      chk(addr_log[16] == 16'hC490, "R9 R8 sequence not restarted", addr_log[16], 16'hC490);
      chk(irq == 1'b0, "R7 no irq in mode 0", irq, 0);
      wait_cyc(10 * 54);

      // R6 wrap into upper half
      cfg(2'd0, {2'b10, 2'b00, 4'hF});
      cfg(2'd2, 8'hFF);
      cfg(2'd3, 8'h04);
      nfetch = 0;
      enable(1'b1);
      wait_inactive(70 * 432);
      chk(nfetch == 65, "R6 count", nfetch, 65);
      chk(addr_log[0] == 16'hFFC0, "R6 first address", addr_log[0], 16'hFFC0);
      chk(addr_log[63] == 16'hFFFF, "R6 top address", addr_log[63], 16'hFFFF);
      chk(addr_log[64] == 16'h8000, "R6 wrap address", addr_log[64], 16'h8000);
      chk(irq == 1'b1, "R7 irq in mode 2", irq, 1);
      wait_cyc(10 * 54);

      // R7 loop mode
      cfg(2'd0, {2'b01, 2'b00, 4'hF});
      cfg(2'd2, 8'h03);
      cfg(2'd3, 8'h00);
      nfetch = 0;
      enable(1'b1);
      chk(irq == 1'b0, "R8 start clears irq", irq, 0);
      wait_cyc(4 * 432 + 100);
      chk(active == 1'b1, "R7 loop stays active", active, 1);
      chk(nfetch >= 4, "R7 loop refetches", nfetch, 4);
      all_same = 1'b1;
      for (int i = 0; i < nfetch && i < 128; i++)
         if (addr_log[i] != 16'hC0C0) all_same = 1'b0;
      chk(all_same, "R7 loop reloads start", all_same, 1);

      // R8 stop
      enable(1'b0);
      chk(active == 1'b0, "R8 stop", active, 0);
      chk(mem_req == 1'b0, "R8 stop drops request", mem_req, 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule